// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block watches one outstanding bus cycle at a time and ends it with a bus error strobe when no acknowledge arrives within a programmable number of microsecond ticks. Software controls it through a single command word at byte offset 0x00. That word holds a timer enable, a global bus enable, a two-bit timeout select, an interrupt enable and an enable for the error strobe (the auxiliary error logic). It also holds a sticky error status bit that is cleared by writing a one to it. A second word at offset 0x04 holds a six-bit address-modifier value that is only stored and read back. Several byte-order control bits in the command word are also only stored.

A cycle-start strobe arms the monitor and clears its count. Each microsecond tick then advances the count, and an acknowledge strobe disarms the monitor. When the count reaches the selected limit, three things happen. The status bit sets, the interrupt line follows it if interrupts are enabled, and a one-cycle error strobe is issued if the auxiliary logic is enabled. The four limits are parameters, with defaults of 16, 64, 256 and 1000 ticks.

Top module: `bto_monitor`

## Requirements
- R1: After reset, both register words read 0, and err_status, irq and berr_pulse are 0.
- R2: At offset 0x00, bits 0,1,2,3,4,5,6,8,10,11 store the written value and read it back. Bits 9 and 31:12 always read 0. Bit 7 reads the error status and is not stored.
- R3: The error status (bit 7) stays set until a write to offset 0x00 carries a 1 in bit 7, which clears it. Writing 0 in bit 7 leaves it unchanged.
- R4: With bit 3 (timer enable), bit 11 (bus enable) and bit 2 (auxiliary enable) at 1, a cycle start followed by L ticks with no acknowledge has two effects. After the clock edge that takes the L-th tick, berr_pulse is 1 for exactly one cycle, and err_status becomes 1 on the same cycle.
- R5: Bits 5:4 choose L: 00 gives LIM_16US, 01 gives LIM_64US, 10 gives LIM_256US and 11 gives LIM_1MS. Only ticks are counted, not clock cycles.
- R6: An acknowledge taken at or before the edge of the L-th tick disarms the monitor. No strobe and no status follow.
- R7: When bit 3 or bit 11 is 0, no timeout is produced, whatever the ticks.
- R8: irq equals err_status AND bit 6 (interrupt enable).
- R9: With bit 2 at 0, a timeout still sets err_status but produces no berr_pulse.
- R10: Offset 0x04 stores the low 6 bits of a write and reads them back with the upper bits 0. Any other offset reads 0, and writes to it change nothing.
- R11: A cycle start while a cycle is being watched restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cyc_start | input | 1 | One-cycle strobe: a bus cycle begins |
| cyc_ack | input | 1 | One-cycle strobe: the bus cycle is acknowledged |
| us_tick | input | 1 | One-cycle microsecond time base pulse |
| berr_pulse | output | 1 | One-cycle bus error strobe that ends the cycle |
| err_status | output | 1 | Sticky timeout status |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume a few things about the inputs. Start and acknowledge are single-cycle strobes that never occur together. A new start comes only when a restart is wanted. The tick never lasts longer than one cycle per pulse. The stimulus keeps to these rules. It raises a start only on a cycle with no tick, it drops start and acknowledge after one clock, and it spaces the ticks by a fixed period of one or two cycles. Within those rules, the sweep covers every timeout select, both tick periods and every acknowledge position from the first edge to one past the limit. The expected strobe cycle is computed by counting ticks in the bench.

// File: rtl/bto_pkg.sv
package bto_pkg;
   localparam int DATA_W     = 32;
   localparam int BIT_MST_BE = 0;
   localparam int BIT_SLV_BE = 1;
   localparam int BIT_AUX    = 2;
   localparam int BIT_TMR_EN = 3;
   localparam int BIT_TSEL   = 4;
   localparam int BIT_IRQ_EN = 6;
   localparam int BIT_STATUS = 7;
   localparam int BIT_SPARE  = 8;
   localparam int BIT_BYPASS = 10;
   localparam int BIT_BUS_EN = 11;
   localparam logic [DATA_W-1:0] STORE_MASK = 32'h0000_0D7F;

   typedef struct packed {
      logic       bus_en;
      logic       bypass;
      logic       spare;
      logic       irq_en;
      logic [1:0] tsel;
      logic       tmr_en;
      logic       aux_en;
      logic       slv_be;
      logic       mst_be;
   } cmd_t;

   typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WATCH = 1'b1} wstate_t;
endpackage

// File: rtl/bto_cmd_regs.sv
module bto_cmd_regs
   import bto_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int AM_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              set_err,
   output cmd_t              cmd,
   output logic              status,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] OFS_CMD = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_AM  = ADDR_W'(4);

   logic [DATA_W-1:0] cmd_q;
   logic [AM_W-1:0]   am_q;
   logic              status_q;
   logic              hit_cmd, hit_am;
   logic              unused_wbits;

   assign hit_cmd = (addr == OFS_CMD);
   assign hit_am  = (addr == OFS_AM);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= '0;
         am_q  <= '0;
      end else if (wr) begin
         if (hit_cmd) cmd_q <= wdata & STORE_MASK;
         if (hit_am)  am_q  <= wdata[AM_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                                    status_q <= 1'b0;
      else if (set_err)                              status_q <= 1'b1;
      else if (wr && hit_cmd && wdata[BIT_STATUS])   status_q <= 1'b0;
   end

   always_comb begin
      cmd.mst_be = cmd_q[BIT_MST_BE];
      cmd.slv_be = cmd_q[BIT_SLV_BE];
      cmd.aux_en = cmd_q[BIT_AUX];
      cmd.tmr_en = cmd_q[BIT_TMR_EN];
      cmd.tsel   = cmd_q[BIT_TSEL+1:BIT_TSEL];
      cmd.irq_en = cmd_q[BIT_IRQ_EN];
      cmd.spare  = cmd_q[BIT_SPARE];
      cmd.bypass = cmd_q[BIT_BYPASS];
      cmd.bus_en = cmd_q[BIT_BUS_EN];
   end

   always_comb begin
      rdata = '0;
      if (hit_cmd) begin
         rdata = cmd_q & STORE_MASK;
         rdata[BIT_STATUS] = status_q;
      end else if (hit_am) begin
         rdata[AM_W-1:0] = am_q;
      end
   end

   assign status = status_q;
endmodule

// File: rtl/bto_limit_sel.sv
module bto_limit_sel #(
   parameter int CNT_W = 10,
   parameter int LIM0  = 16,
   parameter int LIM1  = 64,
   parameter int LIM2  = 256,
   parameter int LIM3  = 1000,
   parameter int STYLE = 0
) (
   input  logic [1:0]       sel,
   output logic [CNT_W-1:0] lim_m1
);
   generate
      if (STYLE == 0) begin : g_mux
         always_comb begin
            unique case (sel)
               2'd0:    lim_m1 = CNT_W'(LIM0 - 1);
               2'd1:    lim_m1 = CNT_W'(LIM1 - 1);
               2'd2:    lim_m1 = CNT_W'(LIM2 - 1);
               default: lim_m1 = CNT_W'(LIM3 - 1);
            endcase
         end
      end else begin : g_table
         localparam logic [CNT_W-1:0] LUT [4] = '{
            CNT_W'(LIM0 - 1), CNT_W'(LIM1 - 1), CNT_W'(LIM2 - 1), CNT_W'(LIM3 - 1)};
         assign lim_m1 = LUT[sel];
      end
   endgenerate
endmodule

// File: rtl/bto_timer.sv
module bto_timer
   import bto_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             cyc_start,
   input  logic             cyc_ack,
   input  logic             us_tick,
   input  logic [CNT_W-1:0] lim_m1,
   output logic             active,
   output logic             hit
);
   wstate_t          state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_lim;

   assign at_lim = (cnt_q == lim_m1);
   assign active = (state_q == ST_WATCH);
   assign hit    = run_en && active && !cyc_ack && !cyc_start && us_tick && at_lim;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (!run_en) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (cyc_ack) begin
         state_q <= ST_IDLE;
      end else if (cyc_start) begin
         state_q <= ST_WATCH;
         cnt_q   <= '0;
      end else if (active && us_tick) begin
         if (at_lim) state_q <= ST_IDLE;
         else        cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/bto_monitor.sv
module bto_monitor
   import bto_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int AM_W      = 6,
   parameter int LIM_16US  = 16,
   parameter int LIM_64US  = 64,
   parameter int LIM_256US = 256,
   parameter int LIM_1MS   = 1000,
   parameter int SEL_STYLE = 0,
   parameter int IRQ_REG   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              cyc_start,
   input  logic              cyc_ack,
   input  logic              us_tick,
   output logic              berr_pulse,
   output logic              err_status,
   output logic              irq
);
   localparam int CNT_W = (LIM_1MS > 1) ? $clog2(LIM_1MS) : 1;

   generate
      if (LIM_16US < 1) begin : g_chk_min
         $error("smallest timeout limit must be at least one tick");
      end
      if (!(LIM_16US < LIM_64US && LIM_64US < LIM_256US && LIM_256US < LIM_1MS)) begin : g_chk_order
         $error("timeout limits must rise strictly with the select code");
      end
      if (ADDR_W < 3) begin : g_chk_addr
         $error("address width too small to reach offset 4");
      end
      if (AM_W < 1 || AM_W > 32) begin : g_chk_am
         $error("address-modifier width out of range");
      end
   endgenerate

   cmd_t             cmd;
   logic             hit, tmr_active, berr_q;
   logic             tmr_en, bus_en, irq_en, aux_en;
   logic [CNT_W-1:0] lim_m1;
   logic             unused_cmd;

   assign tmr_en     = cmd.tmr_en;
   assign bus_en     = cmd.bus_en;
   assign irq_en     = cmd.irq_en;
   assign aux_en     = cmd.aux_en;
   assign unused_cmd = ^{cmd.mst_be, cmd.slv_be, cmd.spare, cmd.bypass};

   bto_cmd_regs #(.ADDR_W(ADDR_W), .AM_W(AM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .set_err(hit), .cmd(cmd), .status(err_status), .rdata(reg_rdata));

   bto_limit_sel #(.CNT_W(CNT_W), .LIM0(LIM_16US), .LIM1(LIM_64US),
                   .LIM2(LIM_256US), .LIM3(LIM_1MS), .STYLE(SEL_STYLE)) u_lim (
      .sel(cmd.tsel), .lim_m1(lim_m1));

   bto_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run_en(tmr_en && bus_en), .cyc_start(cyc_start),
      .cyc_ack(cyc_ack), .us_tick(us_tick), .lim_m1(lim_m1),
      .active(tmr_active), .hit(hit));

   always_ff @(posedge clk) begin
      if (!rst_n) berr_q <= 1'b0;
      else        berr_q <= hit && aux_en;
   end
   assign berr_pulse = berr_q;

   generate
      if (IRQ_REG != 0) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= err_status && irq_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = err_status && irq_en;
      end
   endgenerate
endmodule

// File: rtl/bto_monitor_chk.sv
module bto_monitor_chk #(
   parameter int ADDR_W  = 4,
   parameter int IRQ_REG = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              wbit_status,
   input logic [19:0]       rd_hi,
   input logic              rd_b9,
   input logic              cyc_ack,
   input logic              berr_pulse,
   input logic              err_status,
   input logic              irq,
   input logic              tmr_en,
   input logic              bus_en,
   input logic              irq_en,
   input logic              aux_en
);
   logic clr_wr;
   assign clr_wr = reg_wr && (reg_addr == ADDR_W'(0)) && wbit_status;

   AST_BERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      berr_pulse |=> !berr_pulse); // R4
   AST_BERR_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      berr_pulse |-> err_status); // R4
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_status && !clr_wr) |=> err_status); // R3
   AST_ACK_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_ack |=> !berr_pulse); // R6
   AST_NO_RUN_NO_BERR: assert property (@(posedge clk) disable iff (!rst_n)
      !(tmr_en && bus_en) |=> !berr_pulse); // R7
   AST_AUX_GATES_BERR: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_en |=> !berr_pulse); // R9
   AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> (rd_hi == '0 && !rd_b9)); // R2

   generate
      if (IRQ_REG == 0) begin : g_irq_prop
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            irq == (err_status && irq_en)); // R8
      end
   endgenerate
endmodule

bind bto_monitor bto_monitor_chk #(.ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .wbit_status(reg_wdata[7]), .rd_hi(reg_rdata[31:12]), .rd_b9(reg_rdata[9]),
   .cyc_ack(cyc_ack), .berr_pulse(berr_pulse), .err_status(err_status), .irq(irq),
   .tmr_en(tmr_en), .bus_en(bus_en), .irq_en(irq_en), .aux_en(aux_en));

// File: tb/sim_bto_monitor.sv
`timescale 1ns/1ps
module sim_bto_monitor;
   localparam int AW = 4;
   localparam int LIMS [4] = '{3, 5, 8, 12};
   localparam logic [31:0] EN_RUN = 32'h0000_0808;
   localparam logic [31:0] EN_AUX = 32'h0000_0004;
   localparam logic [31:0] EN_IRQ = 32'h0000_0040;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          cyc_start = 1'b0, cyc_ack = 1'b0, us_tick = 1'b0;
   logic          berr_pulse, err_status, irq;
   int            total = 0, bad = 0;

   always #4 clk = ~clk;

   bto_monitor #(.ADDR_W(AW), .LIM_16US(3), .LIM_64US(5), .LIM_256US(8), .LIM_1MS(12)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cyc_start(cyc_start), .cyc_ack(cyc_ack), .us_tick(us_tick),
      .berr_pulse(berr_pulse), .err_status(err_status), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
      reg_addr = '0;
   endtask

   // Start one cycle, then tick every `period` cycles; ack on edge ack_at (0 = never).
   // Counts cycles where berr_pulse differs from the tick-count model.
   task automatic run_cycle(input int lim, input int period, input int ack_at,
                            input bit aux, input bit armed,
                            output int mism, output bit hit);
      int n, cnt;
      bit live, expb;
      n = lim * period + 3;
      @(negedge clk);
      cyc_start = 1'b1; us_tick = 1'b0; cyc_ack = 1'b0;
      @(negedge clk);
      cyc_start = 1'b0;
      cnt = 0; live = armed; hit = 1'b0; mism = 0;
      for (int i = 1; i <= n; i++) begin
         us_tick = (i % period == 0);
         cyc_ack = (i == ack_at);
         @(negedge clk);
         expb = 1'b0;
         if (live) begin
            if (i == ack_at) live = 1'b0;
            else if (us_tick) begin
               cnt++;
               if (cnt == lim) begin expb = aux; hit = 1'b1; live = 1'b0; end
            end
         end
         if (berr_pulse !== expb) mism++;
      end
      us_tick = 1'b0; cyc_ack = 1'b0;
   endtask

   initial begin
      #(64'd8 * 150000);
      total++; bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int mism;
      bit hit;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, d); chk("R1 cmd word", d, 0);
      rd(4, d); chk("R1 am word", d, 0);
      chk("R1 status", {31'd0, err_status}, 0);
      chk("R1 irq", {31'd0, irq}, 0);
      chk("R1 berr", {31'd0, berr_pulse}, 0);

      // R2 walking-one store/readback, bus enable kept out of combination
      for (int b = 0; b < 32; b++) begin
         wr(0, 32'h1 << b);
         rd(0, d);
         chk($sformatf("R2 bit %0d", b), d, (32'h1 << b) & 32'h0000_0D7F);
      end
      wr(0, 32'hFFFF_FFFF); rd(0, d); chk("R2 all ones", d, 32'h0000_0D7F);
      wr(0, 32'h0); rd(0, d); chk("R2 zero", d, 0);

      // R10 second word and other offsets
      wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R10 am ones", d, 32'h3F);
      wr(4, 32'h0000_0015); rd(4, d); chk("R10 am pattern", d, 32'h15);
      wr(0, 32'h0000_0503);
      wr(8, 32'hFFFF_FFFF);
      rd(8, d); chk("R10 other offset", d, 0);
      rd(0, d); chk("R10 cmd untouched", d, 32'h0000_0503);
      rd(4, d); chk("R10 am untouched", d, 32'h15);

      // R4 R5 R6 R8 R3 sweep: select, tick period, acknowledge position
      for (int s = 0; s < 4; s++) begin
         for (int p = 1; p <= 2; p++) begin
            for (int a = 0; a <= LIMS[s] * p + 1; a++) begin
               logic [31:0] cmd;
               cmd = EN_RUN | EN_AUX | EN_IRQ | (32'(s) << 4);
               wr(0, cmd);
               run_cycle(LIMS[s], p, a, 1'b1, 1'b1, mism, hit);
               chk($sformatf("R4 R5 R6 berr timing sel=%0d per=%0d ack=%0d", s, p, a), mism, 0);
               chk("R4 R6 status", {31'd0, err_status}, {31'd0, hit});
               chk("R8 irq", {31'd0, irq}, {31'd0, hit});
               wr(0, cmd | 32'h80);
               chk("R3 clear", {31'd0, err_status}, 0);
            end
         end
      end

      // R3 writing 0 in bit 7 keeps status; R8 irq masked then unmasked
      wr(0, EN_RUN | EN_AUX);
      run_cycle(LIMS[0], 1, 0, 1'b1, 1'b1, mism, hit);
      chk("R4 base", mism, 0);
      wr(0, EN_RUN | EN_AUX);
      chk("R3 write 0 keeps", {31'd0, err_status}, 1);
      rd(0, d); chk("R3 readback bit7", d, EN_RUN | EN_AUX | 32'h80);
      chk("R8 irq masked", {31'd0, irq}, 0);
      wr(0, EN_RUN | EN_AUX | EN_IRQ);
      chk("R8 irq unmasked", {31'd0, irq}, 1);
      wr(0, 32'h80);
      chk("R3 clear after", {31'd0, err_status}, 0);

      // R9 auxiliary disabled: status only
      wr(0, EN_RUN | (32'd1 << 4));
      run_cycle(LIMS[1], 1, 0, 1'b0, 1'b1, mism, hit);
      chk("R9 no berr", mism, 0);
      chk("R9 status set", {31'd0, err_status}, 1);
      wr(0, 32'h80);

      // R7 timer enable or bus enable off
      wr(0, 32'h0000_0800 | EN_AUX);
      run_cycle(LIMS[0], 1, 0, 1'b1, 1'b0, mism, hit);
      chk("R7 timer off berr", mism, 0);
      chk("R7 timer off status", {31'd0, err_status}, 0);
      wr(0, 32'h0000_0008 | EN_AUX);
      run_cycle(LIMS[0], 1, 0, 1'b1, 1'b0, mism, hit);
      chk("R7 bus off berr", mism, 0);
      chk("R7 bus off status", {31'd0, err_status}, 0);

      // R11 restart mid-cycle
      wr(0, EN_RUN | EN_AUX | (32'd2 << 4));
      @(negedge clk); cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0;
      for (int i = 0; i < LIMS[2] - 1; i++) begin
         us_tick = 1'b1; @(negedge clk);
      end
      us_tick = 1'b0;
      chk("R11 no early berr", {31'd0, err_status}, 0);
      run_cycle(LIMS[2], 1, 0, 1'b1, 1'b1, mism, hit);
      chk("R11 full count after restart", mism, 0);
      chk("R11 status", {31'd0, err_status}, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule